// File: doc/BRIEF.md
# Display Gamma Lookup Table

This block corrects the colour of a display pixel stream. Every pixel carries a red, a green and a blue component. Each component is used as an address into the correction table, and the matching colour field of that entry replaces it. The corrected pixel leaves one clock later, and its valid, hsync and vsync flags are delayed by the same amount so that they stay aligned with it. Two control inputs decide whether correction is applied. When it is not applied, the pixel passes through unchanged with the same one-cycle delay.

The table is loaded through a 32-bit write port. A build parameter picks one of two layouts:

- **Indexed layout:** 256 entries of 8 bits per component. Each write word names its own entry.
- **Streamed layout:** 1024 entries of 10 bits per component. Writes fill the table through an internal pointer that steps forward after every write, and a flag bit restarts it at entry 0.

Table storage has separate write and read ports, so loading the table never stalls the pixel stream.

Top module: `gamma_lut_top`

## Requirements
- R1: While rst_ni is low, pix_valid_o, hsync_o, vsync_o and pix_o are all 0.
- R2: Indexed layout (STREAMED=0): a write stores wr_data_i[23:0] into the entry whose number is wr_data_i[31:24].
- R3: Each stored entry packs red in bits [3b-1:2b], green in bits [2b-1:b] and blue in bits [b-1:0], where b is 8 in the indexed layout and 10 in the streamed layout. Pixels use the same packing. With correction on, each output component equals that component's field of the entry addressed by the matching input component.
- R4: pix_o, pix_valid_o, hsync_o and vsync_o follow the inputs of the previous clock edge, and an output appears on every cycle.
- R5: Correction is on only when gamma_sel_i and tv_gamma_en_i are both 1. When either is 0, pix_o equals the pix_i of the previous edge.
- R6: Streamed layout (STREAMED=1): a write with wr_data_i[31]=0 stores wr_data_i[29:0] at the write pointer. The pointer then advances by one, and it wraps to 0 after entry 1023.
- R7: Streamed layout: a write with wr_data_i[31]=1 stores its data at entry 0, and the pointer then moves to 1.
- R8: If a write and a pixel lookup use the same entry in the same cycle, the lookup returns the old contents. The next lookup of that entry returns the new contents.
- R9: Reset returns the streamed write pointer to entry 0, so the first write after reset without the restart bit lands in entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gamma_sel_i | input | 1 | Selects table correction instead of palette operation |
| tv_gamma_en_i | input | 1 | Enables correction on this output channel |
| wr_en_i | input | 1 | Table write strobe |
| wr_data_i | input | 32 | Table write word |
| pix_valid_i | input | 1 | Input pixel valid |
| hsync_i | input | 1 | Input horizontal sync |
| vsync_i | input | 1 | Input vertical sync |
| pix_i | input | 3*b | Input pixel, packed red/green/blue |
| pix_valid_o | output | 1 | Output pixel valid |
| hsync_o | output | 1 | Output horizontal sync |
| vsync_o | output | 1 | Output vertical sync |
| pix_o | output | 3*b | Output pixel, corrected or passed through |

## Verification
A table write and a pixel lookup can hit the same entry in the same cycle. The bench provokes this by writing entry 5 in the cycle where every component of the pixel is 5. It also writes streamed entries while pixels read the entry that was just refilled. The scoreboard takes each expected value from its model before applying that cycle's write. The collision cycle is therefore judged against the old entry, and the following cycle against the new one.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int NCOMP       = 3;
  localparam int WORD_W      = 32;
  localparam int IDX_CW      = 8;
  localparam int STR_CW      = 10;
  localparam int IDX_DEPTH   = 256;
  localparam int STR_DEPTH   = 1024;
  localparam int IDX_POS     = 24;
  localparam int RESTART_POS = 31;

  function automatic int comp_w(bit streamed);
    return streamed ? STR_CW : IDX_CW;
  endfunction

  function automatic int tbl_depth(bit streamed);
    return streamed ? STR_DEPTH : IDX_DEPTH;
  endfunction
endpackage

// File: rtl/gamma_wr_ctrl.sv
module gamma_wr_ctrl
  import gamma_pkg::*;
#(
  parameter bit STREAMED = 1'b0,
  parameter int AW       = 8,
  parameter int EW       = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [EW-1:0]     wdata_o
);
  assign we_o    = wr_en_i;
  assign wdata_o = wr_data_i[EW-1:0];

  if (STREAMED) begin : g_str
    logic [AW-1:0] ptr_q;
    logic          restart;
    logic          unused_pad;

    assign restart    = wr_data_i[RESTART_POS];
    assign unused_pad = ^wr_data_i[RESTART_POS-1:EW];
    assign waddr_o    = restart ? '0 : ptr_q;

    // pointer wraps by natural overflow of AW bits
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q <= '0;
      else if (wr_en_i) ptr_q <= waddr_o + AW'(1);
    end

    // R6
    ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !wr_data_i[RESTART_POS] |=> ptr_q == $past(ptr_q) + AW'(1));
    // R7
    ptr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_data_i[RESTART_POS] |=> ptr_q == AW'(1));
    // R6
    ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(ptr_q));
  end else begin : g_idx
    assign waddr_o = wr_data_i[IDX_POS +: AW];
  end
endmodule

// File: rtl/gamma_comp_ram.sv
module gamma_comp_ram #(
  parameter int CW    = 8,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o
);
  logic [CW-1:0] mem_q [DEPTH];
  logic [CW-1:0] rdata_q;

  // read sees pre-write contents on address collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gamma_sync_pipe.sv
module gamma_sync_pipe #(
  parameter int W      = 3,
  parameter int STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_pkg::*;
#(
  parameter bit  STREAMED = 1'b0,
  localparam int CW       = comp_w(STREAMED),
  localparam int PW       = NCOMP * CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gamma_sel_i,
  input  logic              tv_gamma_en_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              pix_valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [PW-1:0]     pix_i,
  output logic              pix_valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [PW-1:0]     pix_o
);
  localparam int DEPTH = tbl_depth(STREAMED);
  localparam int AW    = $clog2(DEPTH);
  localparam int LAT   = 1;

  logic          we;
  logic [AW-1:0] waddr;
  logic [PW-1:0] wdata;
  logic [PW-1:0] lut_q;
  logic [PW-1:0] byp_q;
  logic          act_q;
  logic [2:0]    flags_q;

  gamma_wr_ctrl #(.STREAMED(STREAMED), .AW(AW), .EW(PW)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata)
  );

  // one table copy per component: three independent read ports
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    gamma_comp_ram #(.CW(CW), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk_i  (clk_i),
      .we_i   (we),
      .waddr_i(waddr),
      .wdata_i(wdata[c*CW +: CW]),
      .raddr_i(pix_i[c*CW +: CW]),
      .rdata_o(lut_q[c*CW +: CW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      byp_q <= '0;
    end else begin
      act_q <= gamma_sel_i & tv_gamma_en_i;
      byp_q <= pix_i;
    end
  end

  gamma_sync_pipe #(.W(3), .STAGES(LAT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pix_valid_i, hsync_i, vsync_i}),
    .q_o   (flags_q)
  );

  assign {pix_valid_o, hsync_o, vsync_o} = flags_q;
  assign pix_o = act_q ? lut_q : byp_q;

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !pix_valid_o && !hsync_o && !vsync_o && pix_o == '0);
  // R4
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);
  // R4
  valid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_valid_o);
  // R4
  sync_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hsync_o == $past(hsync_i) && vsync_o == $past(vsync_i));
  // R5
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gamma_sel_i && tv_gamma_en_i) |=> pix_o == $past(pix_i));
endmodule

// File: tb/tb_gamma_lut_top.sv
module tb_gamma_lut_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic sel = 1'b0, en = 1'b0;
  logic we_a = 1'b0, v_a = 1'b0, hs_a = 1'b0, vs_a = 1'b0;
  logic [31:0] wd_a = '0;
  logic [23:0] px_a = '0;
  logic we_b = 1'b0, v_b = 1'b0, hs_b = 1'b0, vs_b = 1'b0;
  logic [31:0] wd_b = '0;
  logic [29:0] px_b = '0;
  logic ov_a, ohs_a, ovs_a, ov_b, ohs_b, ovs_b;
  logic [23:0] opx_a;
  logic [29:0] opx_b;

  gamma_lut_top #(.STREAMED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .gamma_sel_i(sel), .tv_gamma_en_i(en),
    .wr_en_i(we_a), .wr_data_i(wd_a), .pix_valid_i(v_a), .hsync_i(hs_a),
    .vsync_i(vs_a), .pix_i(px_a), .pix_valid_o(ov_a), .hsync_o(ohs_a),
    .vsync_o(ovs_a), .pix_o(opx_a));

  gamma_lut_top #(.STREAMED(1'b1)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .gamma_sel_i(sel), .tv_gamma_en_i(en),
    .wr_en_i(we_b), .wr_data_i(wd_b), .pix_valid_i(v_b), .hsync_i(hs_b),
    .vsync_i(vs_b), .pix_i(px_b), .pix_valid_o(ov_b), .hsync_o(ohs_b),
    .vsync_o(ovs_b), .pix_o(opx_b));

  typedef struct {
    logic        v, hs, vs;
    logic [29:0] px;
    string       req;
  } exp_t;

  exp_t q_a[$];
  exp_t q_b[$];
  exp_t ea, eb;
  logic [23:0] mdl_a [256];
  logic [29:0] mdl_b [1024];
  int ptr_m = 0;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [23:0] ent_a(int k);
    return {8'(255 - k), 8'(k ^ 'h5A), 8'(k * 3)};
  endfunction

  function automatic logic [29:0] ent_b(int k);
    return {10'(1023 - k), 10'(k ^ 'h155), 10'(k * 7)};
  endfunction

  // driver: expected is taken before this cycle's write (R8)
  task automatic drive_a(input bit we, input logic [31:0] wd, input bit v, hs, vs,
                         input logic [23:0] px, input string req);
    exp_t e;
    we_a = we; wd_a = wd; v_a = v; hs_a = hs; vs_a = vs; px_a = px;
    e.v = v; e.hs = hs; e.vs = vs; e.req = req;
    if (sel && en)
      e.px = {6'b0, mdl_a[px[23:16]][23:16], mdl_a[px[15:8]][15:8], mdl_a[px[7:0]][7:0]};
    else
      e.px = {6'b0, px};
    q_a.push_back(e);
    if (we) mdl_a[wd[31:24]] = wd[23:0];
    @(negedge clk);
  endtask

  task automatic drive_b(input bit we, input logic [31:0] wd, input bit v, hs, vs,
                         input logic [29:0] px, input string req);
    exp_t e;
    we_b = we; wd_b = wd; v_b = v; hs_b = hs; vs_b = vs; px_b = px;
    e.v = v; e.hs = hs; e.vs = vs; e.req = req;
    if (sel && en)
      e.px = {mdl_b[px[29:20]][29:20], mdl_b[px[19:10]][19:10], mdl_b[px[9:0]][9:0]};
    else
      e.px = px;
    q_b.push_back(e);
    if (we) begin
      if (wd[31]) ptr_m = 0;
      mdl_b[ptr_m] = wd[29:0];
      ptr_m = (ptr_m + 1) % 1024;
    end
    @(negedge clk);
  endtask

  // monitors
  always @(posedge clk) begin
    #1;
    if (q_a.size() > 0) begin
      ea = q_a.pop_front();
      chk({ov_a, ohs_a, ovs_a, 6'b0, opx_a} === {ea.v, ea.hs, ea.vs, ea.px}, ea.req,
          64'({ov_a, ohs_a, ovs_a, 6'b0, opx_a}), 64'({ea.v, ea.hs, ea.vs, ea.px}));
    end
    if (q_b.size() > 0) begin
      eb = q_b.pop_front();
      chk({ov_b, ohs_b, ovs_b, opx_b} === {eb.v, eb.hs, eb.vs, eb.px}, eb.req,
          64'({ov_b, ohs_b, ovs_b, opx_b}), 64'({eb.v, eb.hs, eb.vs, eb.px}));
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk({ov_a, ohs_a, ovs_a, opx_a} === '0, "R1 indexed reset", 64'({ov_a, ohs_a, ovs_a, opx_a}), 64'd0);
    chk({ov_b, ohs_b, ovs_b, opx_b} === '0, "R1 streamed reset", 64'({ov_b, ohs_b, ovs_b, opx_b}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load in permuted order, R5 bypass (sel=1, en=0)
    sel = 1'b1; en = 1'b0;
    for (int k = 0; k < 256; k++) begin
      int idx = (k * 37) % 256;
      drive_a(1'b1, {8'(idx), ent_a(idx)}, k[0], k[3], k == 0, 24'(k * 40503), "R5 bypass sel-only");
    end
    we_a = 1'b0;

    // R7 restart then R6 sequential fill, R5 bypass (sel=0, en=1)
    sel = 1'b0; en = 1'b1;
    drive_b(1'b1, {2'b10, ent_b(0)}, 1'b1, 1'b0, 1'b1, 30'h2345678, "R7 R5 bypass en-only");
    for (int k = 1; k < 1024; k++)
      drive_b(1'b1, {2'b00, ent_b(k)}, k[1], k[4], 1'b0, 30'(k * 99991), "R6 R5 bypass en-only");
    we_b = 1'b0;

    // R2 R3 R4 lookups
    sel = 1'b1; en = 1'b1;
    for (int k = 0; k < 64; k++)
      drive_a(1'b0, '0, (k % 3) != 0, k[2], k[4], 24'(k * 2654435), "R2 R3 R4 indexed lookup");
    drive_a(1'b0, '0, 1'b1, 1'b1, 1'b1, 24'hFF0000, "R3 corner pixel");
    drive_a(1'b0, '0, 1'b1, 1'b0, 1'b0, 24'h00FFFF, "R3 corner pixel");
    for (int k = 0; k < 64; k++)
      drive_b(1'b0, '0, (k % 5) != 1, k[0], k[3], 30'(k * 87654321), "R3 R4 streamed lookup");
    drive_b(1'b0, '0, 1'b1, 1'b0, 1'b0, {10'd1023, 10'd0, 10'd1023}, "R3 corner pixel");

    // R6 wrap: pointer is past 1023, next plain write lands in entry 0
    drive_b(1'b1, {2'b00, 30'h15555555}, 1'b0, 1'b0, 1'b0, '0, "R6 wrap write");
    drive_b(1'b0, '0, 1'b1, 1'b0, 1'b0, 30'h0, "R6 wrap readback");
    // R7 mid-stream restart
    drive_b(1'b1, {2'b00, 30'h0AAAAAAA}, 1'b0, 1'b0, 1'b0, '0, "R7 prewrite");
    drive_b(1'b1, {2'b00, 30'h03333333}, 1'b0, 1'b0, 1'b0, '0, "R7 prewrite");
    drive_b(1'b1, {2'b10, 30'h0F0F0F0F}, 1'b0, 1'b0, 1'b0, '0, "R7 restart write");
    drive_b(1'b1, {2'b00, 30'h30C30C30}, 1'b0, 1'b0, 1'b0, '0, "R7 follow write");
    drive_b(1'b0, '0, 1'b1, 1'b0, 1'b0, {10'd1, 10'd0, 10'd2}, "R7 readback");
    drive_b(1'b0, '0, 1'b1, 1'b0, 1'b0, {10'd0, 10'd1, 10'd3}, "R7 readback");
    // streamed collision: pointer now at 2, pixel reads entry 2
    drive_b(1'b1, {2'b00, 30'h2DB6DB6D}, 1'b1, 1'b0, 1'b0, {10'd2, 10'd2, 10'd2}, "R8 streamed old");
    drive_b(1'b0, '0, 1'b1, 1'b0, 1'b0, {10'd2, 10'd2, 10'd2}, "R8 streamed new");
    we_b = 1'b0;

    // R8 indexed collision on entry 5
    drive_a(1'b1, {8'd5, 24'h123456}, 1'b1, 1'b0, 1'b0, {8'd5, 8'd5, 8'd5}, "R8 indexed old");
    drive_a(1'b0, '0, 1'b1, 1'b0, 1'b0, {8'd5, 8'd5, 8'd5}, "R8 indexed new");

    // R5 both controls off
    sel = 1'b0; en = 1'b0;
    for (int k = 0; k < 8; k++)
      drive_a(1'b0, '0, 1'b1, k[0], 1'b0, 24'(k * 1234567), "R5 bypass both off");
    sel = 1'b1; en = 1'b1;
    drive_a(1'b0, '0, 1'b1, 1'b0, 1'b0, 24'h0A0B0C, "R5 re-enable");
    drain();

    // R9 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk({ov_a, ohs_a, ovs_a, opx_a} === '0, "R1 mid reset", 64'({ov_a, ohs_a, ovs_a, opx_a}), 64'd0);
    chk({ov_b, ohs_b, ovs_b, opx_b} === '0, "R1 mid reset", 64'({ov_b, ohs_b, ovs_b, opx_b}), 64'd0);
    rst_n = 1'b1;
    ptr_m = 0;
    @(negedge clk);
    drive_b(1'b1, {2'b00, 30'h1E1E1E1E}, 1'b0, 1'b0, 1'b0, '0, "R9 first write");
    drive_b(1'b0, '0, 1'b1, 1'b1, 1'b1, 30'h0, "R9 readback entry 0");
    we_b = 1'b0;
    drain();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule